// File: doc/BRIEF.md
# I2C Serial EEPROM Read Target

This block is an I2C target that behaves like a small serial EEPROM. The storage is an internal byte array whose size is a parameter. It listens to SCL and SDA through synchronisers. When it sees a bus condition, a bit or an acknowledge slot, it reacts on the edges of the synchronised SCL. It pulls SDA low through an output enable and never drives it high. The system clock must run well above the SCL rate, so that every SCL phase lasts several clock cycles.

The block keeps one address counter, and every access mode uses it. A write-mode select followed by an address byte loads the counter. If a repeated Start follows, with a read-mode select, the read begins at that loaded address. A read-mode select straight after a Start returns data from wherever the counter already points. Each byte sent to the master moves the counter on by one, wrapping at the end of the array. The master's acknowledge decides whether another byte follows. Data bytes sent after the address byte are stored with no programming delay, unless the write-protect input is high. Reads never depend on that input.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, SDA is released, the address counter is 0, and the byte at address a holds (a*37+11) mod 256.
- R2: A select byte is acknowledged only when bits 7:4 equal 1010 and bits 3:1 equal the strap inputs. Bit 0 is the read flag (1 = read). Any other select gets no acknowledge, and SDA stays released until the next Start.
- R3: A Start followed by a read-mode select returns the byte at the current counter value, with no address phase.
- R4: A write-mode select followed by an address byte acknowledges both bytes and loads the counter. A repeated Start and read-mode select then return the byte at that address.
- R5: When the master acknowledges a byte, the next byte is the one at the following address. The address wraps from the last location to 0.
- R6: When the master does not acknowledge a byte, SDA stays released until Start or Stop. The next read continues at the address after the last byte sent.
- R7: Data bytes that follow the address byte are acknowledged. Each one is stored at the counter, which then advances, but only while write-protect is low. Reads behave the same at either write-protect level.
- R8: A Stop releases SDA and keeps the counter value, so that a later current-address read uses it.
- R9: SDA is changed only while SCL is low. Bits are sampled on SCL rising, and a Start restarts bit counting.
- R10: In a random read, a second select whose upper seven bits differ from the first select is not acknowledged, and the counter keeps the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| strap_i | input | 3 | Device address straps compared with select bits 3:1 |
| wr_protect_i | input | 1 | High blocks storage of data bytes |

## Verification
A wrong counter value shows up as a wrong data byte in the very next read. This holds whether the counter went wrong through a bad load, a missed increment or a bad wrap. For that reason the bench reads long sequential runs and loads many spread-out addresses. A bit counter or phase flag that slips by one places the acknowledge pulse in the wrong slot or shifts the read data by a bit. Either fault is visible within the same byte. A decoder that matches too widely shows up as an acknowledge to a foreign select, in the ninth bit of that byte.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int          MEM_BYTES   = 256,
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  TYPE_CODE   = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wr_protect_i
);
  localparam int AW = $clog2(MEM_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_ADDR, S_WR, S_RD} st_t;

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_sy[SYNC_STAGES-1];
      sda_d  <= sda_sy[SYNC_STAGES-1];
    end

  wire scl_s     = scl_sy[SYNC_STAGES-1];
  wire sda_s     = sda_sy[SYNC_STAGES-1];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  st_t          st;
  logic [7:0]   sh;
  logic [3:0]   bitcnt;
  logic         ackph, rw, mack;
  logic [AW-1:0] cnt;
  logic [7:0]   mem [MEM_BYTES];

  wire [7:0] mem_q  = mem[cnt];
  wire       sel_ok = sh[7:1] == {TYPE_CODE, strap_i};
  wire       in_idle = st == S_IDLE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; bitcnt <= '0; ackph <= 1'b0;
      rw <= 1'b0; mack <= 1'b0; cnt <= '0; sda_oe <= 1'b0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'(i * 37 + 11);
    end else if (start_det) begin
      st <= S_DEV; bitcnt <= '0; ackph <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE; ackph <= 1'b0; sda_oe <= 1'b0;
    end else if (st == S_RD) begin
      if (scl_rise && ackph) mack <= ~sda_s;
      if (scl_fall) begin
        if (!ackph) begin
          if (bitcnt == 4'd7) begin
            sda_oe <= 1'b0;
            ackph  <= 1'b1;
          end else begin
            sh     <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
            bitcnt <= bitcnt + 4'd1;
          end
        end else if (mack) begin
          sh     <= mem_q;
          sda_oe <= ~mem_q[7];
          cnt    <= cnt + AW'(1);
          bitcnt <= '0;
          ackph  <= 1'b0;
        end else begin
          st    <= S_IDLE;
          ackph <= 1'b0;
        end
      end
    end else if (st != S_IDLE) begin
      if (scl_rise && !ackph && bitcnt != 4'd8) begin
        sh     <= {sh[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end
      if (scl_fall && bitcnt == 4'd8) begin
        if (!ackph) begin
          ackph  <= 1'b1;
          sda_oe <= 1'b1;
          case (st)
            S_DEV: begin
              rw <= sh[0];
              if (!sel_ok) begin
                st     <= S_IDLE;
                ackph  <= 1'b0;
                sda_oe <= 1'b0;
              end
            end
            S_ADDR: cnt <= sh[AW-1:0];
            S_WR: begin
              if (!wr_protect_i) mem[cnt] <= sh;
              cnt <= cnt + AW'(1);
            end
            default: ;
          endcase
        end else begin
          ackph  <= 1'b0;
          bitcnt <= '0;
          sda_oe <= 1'b0;
          case (st)
            S_DEV:
              if (rw) begin
                st     <= S_RD;
                sh     <= mem_q;
                sda_oe <= ~mem_q[7];
                cnt    <= cnt + AW'(1);
              end else st <= S_ADDR;
            S_ADDR:  st <= S_WR;
            default: ;
          endcase
        end
      end
    end
endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       start_det,
  input logic       stop_det,
  input logic       in_idle,
  input logic       ack_phase,
  input logic [3:0] bitcnt
);
  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  // R9
  start_resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (bitcnt == 4'd0 && !ack_phase && !in_idle));

  // R9
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .start_det (start_det),
  .stop_det  (stop_det),
  .in_idle   (in_idle),
  .ack_phase (ackph),
  .bitcnt    (bitcnt)
);

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  i2c_eeprom_target i_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .strap_i(strap), .wr_protect_i(wp));

  int checks = 0, errors = 0, viol = 0;
  logic [7:0] shadow [256];
  logic prev_oe = 1'b0, oe_any = 1'b0;
  bit done = 0;

  always @(negedge clk) begin
    if (m_scl && sda_oe != prev_oe) viol++;
    if (sda_oe) oe_any = 1'b1;
    prev_oe = sda_oe;
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] sel(input logic r);
    return {4'b1010, strap, r};
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0; wt(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(1);
    end
    m_sda = 1'b1; wt(H); m_scl = 1'b1; wt(H/2); ack = !sda_line;
    wt(H/2); m_scl = 1'b0; wt(1);
  endtask

  task automatic recv(input logic give_ack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(H); m_scl = 1'b1; wt(H/2); d = {d[6:0], sda_line}; wt(H/2); m_scl = 1'b0; wt(1);
    end
    m_sda = ~give_ack; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(1);
    m_sda = 1'b1;
  endtask

  task automatic load_addr(input int a, input string r);
    logic ack;
    bus_start();
    send(sel(1'b0), ack); chk({r, " write select ack"}, ack, 1);
    send(8'(a), ack);     chk({r, " address ack"}, ack, 1);
  endtask

  task automatic read_seq(input int n, input int first, input string r);
    logic ack;
    logic [7:0] d;
    bus_start();
    send(sel(1'b1), ack); chk({r, " read select ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv(k != n - 1, d);
      chk({r, " data"}, d, shadow[(first + k) % 256]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    for (int a = 0; a < 256; a++) shadow[a] = 8'((a * 37 + 11) & 255);
    wt(4);
    chk("R1 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    wt(4);
    chk("R1 oe after reset", sda_oe, 0);

    // R3 / R1: current read from counter 0, then NACK (R6)
    bus_start();
    send(sel(1'b1), ack); chk("R2 matching select ack", ack, 1);
    recv(1'b0, d);        chk("R3 current read addr 0", d, shadow[0]);
    oe_any = 1'b0;
    for (int i = 0; i < 9; i++) begin
      wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(1);
    end
    chk("R6 released after nack", oe_any, 0);
    bus_stop();
    read_seq(1, 1, "R6 continue after nack");

    // R2: foreign strap and foreign type code
    bus_start();
    send({4'b1010, strap ^ 3'b001, 1'b1}, ack); chk("R2 wrong strap nack", ack, 0);
    oe_any = 1'b0;
    send(8'h00, ack);
    chk("R2 silent until start", oe_any, 0);
    bus_stop();
    bus_start();
    send({4'b1011, strap, 1'b1}, ack); chk("R2 wrong type nack", ack, 0);
    bus_stop();

    // R4: random reads over spread addresses, two bytes each
    for (int a = 3; a < 256; a += 8) begin
      load_addr(a, "R4");
      read_seq(2, a, "R4 random read");
    end
    load_addr(255, "R5");
    read_seq(2, 255, "R5 wrap random");

    // R5: full sequential run with wrap
    load_addr(0, "R5");
    read_seq(258, 0, "R5 sequential");

    // R10: second select with different straps
    load_addr(8'h40, "R10");
    bus_start();
    send({4'b1010, strap ^ 3'b010, 1'b1}, ack); chk("R10 mismatched second select nack", ack, 0);
    bus_stop();
    read_seq(1, 8'h40, "R10 counter kept");

    // R7: data writes with and without protection
    wp = 1'b0;
    load_addr(8'h10, "R7");
    send(8'hC3, ack); chk("R7 data ack", ack, 1);
    send(8'h3C, ack); chk("R7 data ack", ack, 1);
    bus_stop();
    shadow[8'h10] = 8'hC3; shadow[8'h11] = 8'h3C;
    load_addr(8'h10, "R7");
    read_seq(3, 8'h10, "R7 written data");
    wp = 1'b1;
    load_addr(8'h20, "R7");
    send(8'h99, ack); chk("R7 protected data ack", ack, 1);
    bus_stop();
    load_addr(8'h20, "R7");
    read_seq(2, 8'h20, "R7 protected unchanged");
    read_seq(1, 8'h22, "R7 current read under protect");
    wp = 1'b0;

    // R8: stop after address keeps counter
    load_addr(8'h33, "R8");
    bus_stop();
    wt(2);
    chk("R8 released after stop", sda_oe, 0);
    read_seq(1, 8'h33, "R8 current read after stop");

    chk("R9 oe changed while scl high", viol, 0);
    finish_run();
  end
endmodule